// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction on every rising clock edge. It executes a fixed set of twelve integer operations from the classic MIPS32 encoding: word load and store, absolute jump, jump-and-link, register jump, branch-if-equal, branch-if-not-equal, add-immediate, XOR-immediate, and register add, subtract and signed set-less-than. Any other opcode or function code is retired as a no-op. Pseudo-instructions that an assembler expands are never seen as opcodes.

The core holds the program counter, a 32-entry register file, the decoder, the ALU and the next-address logic. Instruction and data memories sit outside it. The core presents a byte address to each of them and expects the read data back in the same cycle. A store writes on the clock edge that ends the instruction. Program text lives from address 0, and data is normally placed from byte address 0x1000. The memory word index is the byte address shifted right by two. The hardware never presets the stack pointer (register 29), so software loads it itself, typically with 0x3ffc.

Top module: `scp_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 from the first clock edge onward and `dmem_we_o` is 0. The instruction at address 0 executes in the first cycle after `rst` falls.
- R2: Any instruction that is neither a jump nor a taken branch advances `pc_o` by 4 on the next rising edge.
- R3: The R-type instructions (opcode 0x00) write register rd: function 0x20 gives rs+rt, 0x22 gives rs−rt, and 0x2a gives 1 if rs < rt as signed values, otherwise 0. Sums wrap modulo 2^32.
- R4: ADDI (opcode 0x08) writes rs + sign-extended imm16 to rt. XORI (opcode 0x0e) writes rs XOR zero-extended imm16 to rt.
- R5: SW (opcode 0x2b) drives `dmem_addr_o` = rs + sign-extended imm16 and `dmem_wdata_o` = rt with `dmem_we_o` high, and writes no register. LW (opcode 0x23) loads `dmem_rdata_i` at that address into rt.
- R6: BEQ (opcode 0x04) is taken when rs equals rt, and BNE (opcode 0x05) is taken when they differ. A taken branch sets the PC to PC+4 + (sign-extended imm16 << 2); an untaken branch gives PC+4.
- R7: J (opcode 0x02) and JAL (opcode 0x03) set the PC to {PC+4[31:28], target26, 2'b00}. JAL also writes PC+4 into register 31.
- R8: JR (opcode 0x00, function 0x08) sets the PC to the value of register rs.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode, and any other function code under opcode 0x00, writes no register, keeps `dmem_we_o` low and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Byte address of the current instruction |
| instr_i | input | 32 | Instruction word read at `pc_o` |
| dmem_addr_o | output | 32 | Byte address of the load or store |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, taken by memory on the rising edge |
| dmem_rdata_i | input | 32 | Load data read at `dmem_addr_o` |

## Verification
Each scenario is a short program in a modelled memory, and its results are read back through stores. An arithmetic program mixes positive and negative operands, so that signed and unsigned comparison, and sign and zero extension, would give different stored words. A countdown loop takes a backward BNE several times and then runs a forward BEQ taken and a BEQ not taken, which separates the taken path from the fall-through path and catches wrong offset scaling. A call program traces the PC through JAL and JR, and a program with unsupported encodings and register-0 writes shows that none of them leaves a trace in memory or in the registers.

// File: rtl/scp_pkg.sv
package scp_pkg;

  // Fixed instruction layout of the encoding
  localparam int ILEN   = 32;
  localparam int OPW    = 6;
  localparam int RFW    = 5;
  localparam int IMMW   = 16;
  localparam int TGTW   = 26;
  localparam int LINK_R = 31;

  localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPW-1:0] OP_J     = 6'h02;
  localparam logic [OPW-1:0] OP_JAL   = 6'h03;
  localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPW-1:0] OP_BNE   = 6'h05;
  localparam logic [OPW-1:0] OP_ADDI  = 6'h08;
  localparam logic [OPW-1:0] OP_XORI  = 6'h0e;
  localparam logic [OPW-1:0] OP_LW    = 6'h23;
  localparam logic [OPW-1:0] OP_SW    = 6'h2b;

  localparam logic [OPW-1:0] FN_JR  = 6'h08;
  localparam logic [OPW-1:0] FN_ADD = 6'h20;
  localparam logic [OPW-1:0] FN_SUB = 6'h22;
  localparam logic [OPW-1:0] FN_SLT = 6'h2a;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_XOR} alu_op_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

  typedef struct packed {
    logic     reg_we;
    dst_sel_e dst_sel;
    wb_sel_e  wb_sel;
    logic     alu_imm;
    logic     imm_zext;
    alu_op_e  alu_op;
    logic     mem_we;
    logic     br_eq;
    logic     br_ne;
    logic     jump;
    logic     jump_reg;
  } ctrl_t;

endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic [OPW-1:0] funct,
  output ctrl_t          ctl
);

  always_comb begin
    ctl = '0;  // unknown encodings retire as no-ops
    unique case (opcode)
      OP_RTYPE: begin
        unique case (funct)
          FN_ADD: begin
            ctl.reg_we = 1'b1; ctl.dst_sel = DST_RD; ctl.alu_op = ALU_ADD;
          end
          FN_SUB: begin
            ctl.reg_we = 1'b1; ctl.dst_sel = DST_RD; ctl.alu_op = ALU_SUB;
          end
          FN_SLT: begin
            ctl.reg_we = 1'b1; ctl.dst_sel = DST_RD; ctl.alu_op = ALU_SLT;
          end
          FN_JR: ctl.jump_reg = 1'b1;
          default: ;
        endcase
      end
      OP_ADDI: begin
        ctl.reg_we = 1'b1; ctl.dst_sel = DST_RT; ctl.alu_imm = 1'b1;
        ctl.alu_op = ALU_ADD;
      end
      OP_XORI: begin
        ctl.reg_we = 1'b1; ctl.dst_sel = DST_RT; ctl.alu_imm = 1'b1;
        ctl.imm_zext = 1'b1; ctl.alu_op = ALU_XOR;
      end
      OP_LW: begin
        ctl.reg_we = 1'b1; ctl.dst_sel = DST_RT; ctl.alu_imm = 1'b1;
        ctl.alu_op = ALU_ADD; ctl.wb_sel = WB_MEM;
      end
      OP_SW: begin
        ctl.alu_imm = 1'b1; ctl.alu_op = ALU_ADD; ctl.mem_we = 1'b1;
      end
      OP_BEQ: ctl.br_eq = 1'b1;
      OP_BNE: ctl.br_ne = 1'b1;
      OP_J:   ctl.jump  = 1'b1;
      OP_JAL: begin
        ctl.jump = 1'b1; ctl.reg_we = 1'b1;
        ctl.dst_sel = DST_LINK; ctl.wb_sel = WB_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  localparam int DEPTH = 2 ** AW;

  // No reset on the array so it maps onto distributed RAM
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];

  // R3/R4: a written value is what the next read of that entry returns
  a_r3_write_readback: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (raddr_a != $past(waddr) || rdata_a == $past(wdata)));

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_XOR: y = a ^ b;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/scp_nextpc.sv
module scp_nextpc
  import scp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    pc_plus4,
  input  logic [TGTW-1:0] target,
  input  logic [W-1:0]    simm,
  input  logic [W-1:0]    rs_val,
  input  logic            jump,
  input  logic            jump_reg,
  input  logic            take_branch,
  output logic [W-1:0]    pc_next
);

  localparam int REGION = TGTW + 2;

  logic [W-1:0] br_target;
  logic [W-1:0] jmp_target;

  assign br_target  = pc_plus4 + {simm[W-3:0], 2'b00};
  assign jmp_target = {pc_plus4[W-1:REGION], target, 2'b00};

  always_comb begin
    if (jump_reg)         pc_next = rs_val;
    else if (jump)        pc_next = jmp_target;
    else if (take_branch) pc_next = br_target;
    else                  pc_next = pc_plus4;
  end

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc_o,
  input  logic [ILEN-1:0] instr_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4;
  logic [OPW-1:0]  opcode, funct;
  logic [RFW-1:0]  rs, rt, rd, rf_waddr;
  logic [IMMW-1:0] imm;
  logic [XLEN-1:0] simm, zimm, rs_val, rt_val, alu_b, alu_y, rf_wdata;
  logic            rf_we, eq, take_branch;
  ctrl_t           ctl;

  assign opcode = instr_i[31:26];
  assign rs     = instr_i[25:21];
  assign rt     = instr_i[20:16];
  assign rd     = instr_i[15:11];
  assign funct  = instr_i[5:0];
  assign imm    = instr_i[15:0];
  assign simm   = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign zimm   = {{(XLEN-IMMW){1'b0}}, imm};

  always_ff @(posedge clk) begin
    if (rst) pc_q <= XLEN'(RESET_PC);
    else     pc_q <= pc_next;
  end

  assign pc_o     = pc_q;
  assign pc_plus4 = pc_q + STEP;

  scp_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctl    (ctl)
  );

  always_comb begin
    unique case (ctl.dst_sel)
      DST_RT:   rf_waddr = rt;
      DST_LINK: rf_waddr = RFW'(LINK_R);
      default:  rf_waddr = rd;
    endcase
    unique case (ctl.wb_sel)
      WB_MEM:  rf_wdata = dmem_rdata_i;
      WB_LINK: rf_wdata = pc_plus4;
      default: rf_wdata = alu_y;
    endcase
  end

  assign rf_we = ctl.reg_we & ~rst;

  scp_regfile #(.W(XLEN), .AW(RFW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .raddr_a (rs),
    .raddr_b (rt),
    .rdata_a (rs_val),
    .rdata_b (rt_val),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata)
  );

  assign alu_b = ctl.alu_imm ? (ctl.imm_zext ? zimm : simm) : rt_val;

  scp_alu #(.W(XLEN)) u_alu (
    .a  (rs_val),
    .b  (alu_b),
    .op (ctl.alu_op),
    .y  (alu_y)
  );

  assign eq          = (rs_val == rt_val);
  assign take_branch = (ctl.br_eq & eq) | (ctl.br_ne & ~eq);

  scp_nextpc #(.W(XLEN)) u_npc (
    .pc_plus4    (pc_plus4),
    .target      (instr_i[TGTW-1:0]),
    .simm        (simm),
    .rs_val      (rs_val),
    .jump        (ctl.jump),
    .jump_reg    (ctl.jump_reg),
    .take_branch (take_branch),
    .pc_next     (pc_next)
  );

  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;
  assign dmem_we_o    = ctl.mem_we & ~rst;

  // R2: fall-through instructions step the PC by one word
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !ctl.jump_reg && !take_branch) |=> pc_q == $past(pc_q) + STEP);

  // R6: a taken branch lands on the scaled offset past PC+4
  a_r6_branch_target: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> pc_q == $past(pc_plus4) + ($past(simm) << 2));

  // R7: an absolute jump keeps the region bits and loads the target field
  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> pc_q[TGTW+1:0] == {$past(instr_i[TGTW-1:0]), 2'b00});

  // R8: a register jump lands on the rs value
  a_r8_jr_target: assert property (@(posedge clk) disable iff (rst)
    ctl.jump_reg |=> pc_q == $past(rs_val));

  // R5: a store never writes a register
  a_r5_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    dmem_we_o |-> !rf_we);

  // R3: set-less-than yields only 0 or 1
  a_r3_slt_bool: assert property (@(posedge clk) disable iff (rst)
    (ctl.alu_op == ALU_SLT && rf_we) |-> rf_wdata[XLEN-1:1] == '0);

endmodule

// File: tb/scp_core_test.sv
module scp_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc, instr, daddr, dwdata, drdata;
  logic        dwe;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  logic [31:0] imem [64];
  logic [31:0] dmem [4096];

  always #10 clk = ~clk;

  scp_core uut (
    .clk          (clk),
    .rst          (rst),
    .pc_o         (pc),
    .instr_i      (instr),
    .dmem_addr_o  (daddr),
    .dmem_wdata_o (dwdata),
    .dmem_we_o    (dwe),
    .dmem_rdata_i (drdata)
  );

  assign instr  = imem[pc[7:2]];
  assign drdata = dmem[daddr[13:2]];

  always @(posedge clk) begin
    if (dwe) dmem[daddr[13:2]] <= dwdata;
  end

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    for (int i = 0; i < 4096; i++) dmem[i] = 32'hdeadbeef;
  endtask

  task automatic start();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: reset holds the PC at 0 and masks the store strobe
  task automatic t_reset();
    clear_mem();
    imem[0] = enc_i(6'h2b, 0, 0, 16'h0000);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", pc, 32'h0);
    chk("R1 we in reset", {31'b0, dwe}, 32'h0);
    rst = 1'b0;
    #1;
    chk("R1 first instr at 0 stores", {31'b0, dwe}, 32'h1);
    step(1);
  endtask

  // R2 R3 R4: arithmetic with mixed signs, PC trace
  task automatic t_alu();
    clear_mem();
    imem[0]  = enc_i(6'h08, 0, 8, 16'd5);
    imem[1]  = enc_i(6'h08, 0, 9, 16'hfffd);
    imem[2]  = enc_r(8, 9, 10, 6'h20);
    imem[3]  = enc_r(9, 8, 11, 6'h22);
    imem[4]  = enc_r(9, 8, 12, 6'h2a);
    imem[5]  = enc_r(8, 9, 13, 6'h2a);
    imem[6]  = enc_i(6'h0e, 9, 14, 16'h00ff);
    imem[7]  = enc_i(6'h08, 0, 16, 16'h1000);
    imem[8]  = enc_i(6'h2b, 16, 10, 16'd0);
    imem[9]  = enc_i(6'h2b, 16, 11, 16'd4);
    imem[10] = enc_i(6'h2b, 16, 12, 16'd8);
    imem[11] = enc_i(6'h2b, 16, 13, 16'd12);
    imem[12] = enc_i(6'h2b, 16, 14, 16'd16);
    imem[13] = enc_j(6'h02, 26'd13);
    start();
    for (int i = 0; i < 5; i++) begin
      chk("R2 sequential pc", pc, 32'(4 * i));
      step(1);
    end
    step(15);
    chk("R3 add 5+-3", dmem[12'h400], 32'd2);
    chk("R3 sub -3-5", dmem[12'h401], 32'hfffffff8);
    chk("R3 slt signed true", dmem[12'h402], 32'd1);
    chk("R3 slt signed false", dmem[12'h403], 32'd0);
    chk("R4 xori zero-extends", dmem[12'h404], 32'hffffff02);
  endtask

  // R5: store address with a negative offset, load back
  task automatic t_mem();
    clear_mem();
    imem[0] = enc_i(6'h08, 0, 16, 16'h1010);
    imem[1] = enc_i(6'h08, 0, 8, 16'd5);
    imem[2] = enc_i(6'h2b, 16, 8, 16'hfff0);
    imem[3] = enc_i(6'h23, 16, 9, 16'hfff0);
    imem[4] = enc_i(6'h08, 9, 9, 16'd1);
    imem[5] = enc_i(6'h2b, 16, 9, 16'd4);
    imem[6] = enc_j(6'h02, 26'd6);
    start();
    step(2);
    chk("R5 store strobe", {31'b0, dwe}, 32'h1);
    chk("R5 store address", daddr, 32'h1000);
    chk("R5 store data", dwdata, 32'd5);
    step(8);
    chk("R5 stored word", dmem[12'h400], 32'd5);
    chk("R5 load then add", dmem[12'h405], 32'd6);
  endtask

  // R6: backward BNE loop, forward BEQ taken and not taken
  task automatic t_branch();
    clear_mem();
    imem[0]  = enc_i(6'h08, 0, 8, 16'd3);
    imem[1]  = enc_i(6'h08, 0, 9, 16'd0);
    imem[2]  = enc_i(6'h08, 9, 9, 16'd2);
    imem[3]  = enc_i(6'h08, 8, 8, 16'hffff);
    imem[4]  = enc_i(6'h05, 8, 0, 16'hfffd);
    imem[5]  = enc_i(6'h04, 8, 0, 16'd1);
    imem[6]  = enc_i(6'h08, 0, 9, 16'd99);
    imem[7]  = enc_i(6'h04, 8, 9, 16'd1);
    imem[8]  = enc_i(6'h08, 9, 9, 16'd1);
    imem[9]  = enc_i(6'h08, 0, 16, 16'h1000);
    imem[10] = enc_i(6'h2b, 16, 9, 16'd0);
    imem[11] = enc_j(6'h02, 26'd11);
    start();
    step(4);
    chk("R6 bne at 0x10", pc, 32'h10);
    step(1);
    chk("R6 bne taken backward", pc, 32'h8);
    step(30);
    chk("R6 loop and branches result", dmem[12'h400], 32'd7);
  endtask

  // R7 R8: call and return
  task automatic t_jump();
    clear_mem();
    imem[0] = enc_i(6'h08, 0, 16, 16'h1000);
    imem[1] = enc_j(6'h03, 26'd5);
    imem[2] = enc_i(6'h2b, 16, 11, 16'd4);
    imem[3] = enc_j(6'h02, 26'd3);
    imem[4] = enc_i(6'h08, 0, 12, 16'd77);
    imem[5] = enc_i(6'h2b, 16, 31, 16'd0);
    imem[6] = enc_i(6'h08, 0, 11, 16'd42);
    imem[7] = enc_r(31, 0, 0, 6'h08);
    start();
    step(2);
    chk("R7 jal target", pc, 32'h14);
    step(3);
    chk("R8 jr returns", pc, 32'h8);
    step(6);
    chk("R7 link value", dmem[12'h400], 32'h8);
    chk("R8 code after return ran", dmem[12'h401], 32'd42);
  endtask

  // R9 R10: register 0 and unsupported encodings
  task automatic t_ignored();
    clear_mem();
    imem[0] = enc_i(6'h08, 0, 0, 16'd55);
    imem[1] = enc_i(6'h08, 0, 16, 16'h1000);
    imem[2] = enc_i(6'h2b, 16, 0, 16'd0);
    imem[3] = enc_i(6'h08, 0, 9, 16'd11);
    imem[4] = enc_i(6'h0d, 0, 9, 16'h0022);
    imem[5] = enc_r(0, 0, 9, 6'h21);
    imem[6] = enc_i(6'h2b, 16, 9, 16'd4);
    imem[7] = enc_j(6'h02, 26'd7);
    start();
    step(4);
    chk("R10 pc at unknown opcode", pc, 32'h10);
    chk("R10 no store on unknown opcode", {31'b0, dwe}, 32'h0);
    step(1);
    chk("R10 pc steps past unknown", pc, 32'h14);
    chk("R10 no store on unknown funct", {31'b0, dwe}, 32'h0);
    step(6);
    chk("R9 r0 reads zero after write", dmem[12'h400], 32'h0);
    chk("R10 unknown ops left r9", dmem[12'h401], 32'd11);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_ignored();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule